// File: doc/BRIEF.md
# Video Memory Access Front End

This block sits between a CPU-side bus and the three memories a tile-based display engine draws from: a video RAM holding tiles and bitmaps, a palette RAM holding 15-bit colours, and an object attribute RAM holding sprite descriptors. A single request port carries reads and writes of byte, halfword or word width. The block resolves the region, folds the address onto that region's physical storage, applies the byte-write rules of each region, and returns read data in little-endian order one cycle after the request.

Video RAM is laid out as three equal banks, two forming a lower tile area and one forming an object tile area, with the third bank repeated above it so the address window is a power of two. The bank size is set by `BANK_AW` (log2 of one bank in bytes); `BANK_AW = 15` gives the full 96 KiB arrangement, and the default of 9 keeps the storage small. Palette and object RAM sizes are set by `SMALL_AW` (default 10, i.e. 1 KiB each). A 3-bit display mode input moves the start of the protected object tile area for byte writes. A separate output always presents the backdrop colour.

Top module: `vmem_front`

## Requirements
- R1: After reset every byte of all three memories reads as zero, `rd_valid` is 0 and `backdrop` is 0.
- R2: A read request (valid with write low) raises `rd_valid` exactly one cycle later with `rd_data` in the same cycle; `rd_valid` is 0 in every other cycle. Size code 0 returns a byte in bits 7:0, code 1 a halfword in bits 15:0, codes 2 and 3 a word; unused upper bits are zero and bytes are little-endian.
- R3: Halfword accesses ignore address bit 0 and word accesses ignore address bits 1:0.
- R4: Video RAM (select 0) uses the low `BANK_AW+2` address bits; an offset at or above three banks maps to two banks plus its low `BANK_AW` bits.
- R5: Palette RAM (select 1) and object RAM (select 2) use only the low `SMALL_AW` address bits.
- R6: Halfword and word writes store their data little-endian at the folded, aligned offset in every region.
- R7: A byte write to palette RAM or video RAM stores the byte into both bytes of the halfword at the offset with bit 0 cleared.
- R8: A byte write to object RAM leaves its contents unchanged.
- R9: A byte write to video RAM is dropped when its folded offset is at or above two banks in display modes 0 to 2, or at or above two and a half banks in modes 3 to 7.
- R10: Select code 3 writes nothing, and a read with select 3 returns zero.
- R11: `backdrop` equals the little-endian halfword at palette offset 0, reflecting a write from the cycle after it.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_sel | input | 2 | Region: 0 video, 1 palette, 2 object, 3 none |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| bg_mode | input | 3 | Display mode selecting the object tile boundary |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data, zero-extended |
| backdrop | output | 16 | Palette halfword 0 |

## Verification
Directed patterns place word writes and then read them back by byte, halfword and misaligned word to tell byte ordering apart from alignment. Addresses above each region's window separate the three-bank fold of video RAM from the plain wrap of the small memories, and byte writes on either side of both object-area boundaries, under low and high display modes, distinguish the two drop thresholds. A long random sweep over all selects, sizes, modes and addresses then compares every read and the backdrop against a byte-array model on each operation.

// File: rtl/vmem_pkg.sv
package vmem_pkg;

    typedef enum logic [1:0] {
        SEL_VID  = 2'd0,
        SEL_PAL  = 2'd1,
        SEL_OBJ  = 2'd2,
        SEL_NONE = 2'd3
    } vmem_sel_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } vmem_size_e;

    typedef struct packed {
        logic       valid;
        vmem_sel_e  sel;
        vmem_size_e size;
        logic [1:0] lane;
    } vmem_rsp_t;

    localparam int NUM_REGIONS = 3;

endpackage

// File: rtl/vmem_route.sv
module vmem_route
    import vmem_pkg::*;
#(
    parameter int BANK_AW  = 9,
    parameter int SMALL_AW = 10,
    parameter int ADDR_W   = 32,
    parameter int OFF_W    = ((BANK_AW + 2) > SMALL_AW) ? (BANK_AW + 2) : SMALL_AW,
    parameter int ROW_W    = OFF_W - 2
) (
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [1:0]             req_sel,
    input  logic [1:0]             req_size,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [31:0]            req_wdata,
    input  logic [2:0]             bg_mode,
    output logic [NUM_REGIONS-1:0] rd_en,
    output logic [NUM_REGIONS-1:0] we_lo,
    output logic [NUM_REGIONS-1:0] we_hi,
    output logic [ROW_W-1:0]       row,
    output logic [15:0]            wd_lo,
    output logic [15:0]            wd_hi,
    output logic [1:0]             lane
);
    localparam int VID_W = BANK_AW + 2;

    logic [VID_W-1:0] vid_raw;
    logic [VID_W-1:0] vid_off;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] off_al;
    logic             is_byte;
    logic             is_word;
    logic             obj_area;
    logic             write_ok;
    logic [15:0]      half_val;

    always_comb begin
        vid_raw = req_addr[VID_W-1:0];
        // Top bank repeats the object tile bank above it
        if (vid_raw[VID_W-1:VID_W-2] == 2'b11) begin
            vid_off = {2'b10, vid_raw[BANK_AW-1:0]};
        end else begin
            vid_off = vid_raw;
        end

        if (vmem_sel_e'(req_sel) == SEL_VID) begin
            off = OFF_W'(vid_off);
        end else begin
            off = OFF_W'(req_addr[SMALL_AW-1:0]);
        end

        is_byte = (vmem_size_e'(req_size) == SZ_BYTE);
        is_word = req_size[1];

        off_al = off;
        off_al[0] = is_byte ? off[0] : 1'b0;
        if (is_word) begin
            off_al[1] = 1'b0;
        end

        // Protected object tile area for byte writes
        if (bg_mode <= 3'd2) begin
            obj_area = vid_off[VID_W-1];
        end else begin
            obj_area = vid_off[VID_W-1] & vid_off[BANK_AW-1];
        end

        write_ok = req_valid && req_write && (vmem_sel_e'(req_sel) != SEL_NONE);
        if (is_byte && (vmem_sel_e'(req_sel) == SEL_OBJ)) begin
            write_ok = 1'b0;
        end
        if (is_byte && (vmem_sel_e'(req_sel) == SEL_VID) && obj_area) begin
            write_ok = 1'b0;
        end

        half_val = is_byte ? {req_wdata[7:0], req_wdata[7:0]} : req_wdata[15:0];
        wd_lo    = half_val;
        wd_hi    = is_word ? req_wdata[31:16] : half_val;
        row      = off_al[OFF_W-1:2];
        lane     = off_al[1:0];

        for (int r = 0; r < NUM_REGIONS; r++) begin
            rd_en[r] = req_valid && !req_write && (req_sel == 2'(r));
            we_lo[r] = write_ok && (req_sel == 2'(r)) && (is_word || !off_al[1]);
            we_hi[r] = write_ok && (req_sel == 2'(r)) && (is_word ||  off_al[1]);
        end
    end

endmodule

// File: rtl/vmem_bank.sv
module vmem_bank #(
    parameter int DEPTH = 256,
    parameter int ROW_W = 9,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic             rd_en,
    input  logic [ROW_W-1:0] row,
    input  logic [15:0]      wd_lo,
    input  logic [15:0]      wd_hi,
    output logic [31:0]      rdata,
    output logic [15:0]      head
);
    logic [15:0] mem_lo_q [DEPTH];
    logic [15:0] mem_hi_q [DEPTH];
    logic [31:0] rdata_q;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx = row[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_lo_q[i] <= '0;
                mem_hi_q[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (we_lo) mem_lo_q[idx] <= wd_lo;
            if (we_hi) mem_hi_q[idx] <= wd_hi;
            if (rd_en) rdata_q <= {mem_hi_q[idx], mem_lo_q[idx]};
        end
    end

    assign rdata = rdata_q;
    assign head  = mem_lo_q[0];

endmodule

// File: rtl/vmem_front.sv
module vmem_front
    import vmem_pkg::*;
#(
    parameter int BANK_AW  = 9,
    parameter int SMALL_AW = 10,
    parameter int ADDR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_sel,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [2:0]        bg_mode,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic [15:0]       backdrop
);
    localparam int OFF_W = ((BANK_AW + 2) > SMALL_AW) ? (BANK_AW + 2) : SMALL_AW;
    localparam int ROW_W = OFF_W - 2;
    localparam int VID_ROWS   = (3 * (2 ** BANK_AW)) / 4;
    localparam int SMALL_ROWS = 2 ** (SMALL_AW - 2);

    logic [NUM_REGIONS-1:0] rd_en, we_lo, we_hi;
    logic [ROW_W-1:0]       row;
    logic [15:0]            wd_lo, wd_hi;
    logic [1:0]             lane;
    logic [31:0]            rdata_r [NUM_REGIONS];
    logic [15:0]            head_r  [NUM_REGIONS];

    vmem_rsp_t rsp_d, rsp_q;
    logic [31:0] sel_word;

    vmem_route #(
        .BANK_AW (BANK_AW),
        .SMALL_AW(SMALL_AW),
        .ADDR_W  (ADDR_W),
        .OFF_W   (OFF_W),
        .ROW_W   (ROW_W)
    ) i_route (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_sel  (req_sel),
        .req_size (req_size),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .bg_mode  (bg_mode),
        .rd_en    (rd_en),
        .we_lo    (we_lo),
        .we_hi    (we_hi),
        .row      (row),
        .wd_lo    (wd_lo),
        .wd_hi    (wd_hi),
        .lane     (lane)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        localparam int DEPTH = (g == 0) ? VID_ROWS : SMALL_ROWS;
        vmem_bank #(
            .DEPTH(DEPTH),
            .ROW_W(ROW_W)
        ) i_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we_lo(we_lo[g]),
            .we_hi(we_hi[g]),
            .rd_en(rd_en[g]),
            .row  (row),
            .wd_lo(wd_lo),
            .wd_hi(wd_hi),
            .rdata(rdata_r[g]),
            .head (head_r[g])
        );
    end

    always_comb begin
        rsp_d.valid = req_valid && !req_write;
        rsp_d.sel   = vmem_sel_e'(req_sel);
        rsp_d.size  = vmem_size_e'(req_size);
        rsp_d.lane  = lane;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    always_comb begin
        case (rsp_q.sel)
            SEL_VID: sel_word = rdata_r[0];
            SEL_PAL: sel_word = rdata_r[1];
            SEL_OBJ: sel_word = rdata_r[2];
            default: sel_word = '0;
        endcase

        rd_data = '0;
        if (rsp_q.valid) begin
            case (rsp_q.size)
                SZ_BYTE: rd_data = {24'd0, sel_word[8*rsp_q.lane +: 8]};
                SZ_HALF: rd_data = {16'd0, rsp_q.lane[1] ? sel_word[31:16] : sel_word[15:0]};
                default: rd_data = sel_word;
            endcase
        end
        rd_valid = rsp_q.valid;
        backdrop = head_r[1];
    end

endmodule

// File: rtl/vmem_front_chk.sv
module vmem_front_chk #(
    parameter int SMALL_AW = 10,
    parameter int ADDR_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_sel,
    input logic [1:0]        req_size,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rd_valid,
    input logic [31:0]       rd_data,
    input logic [15:0]       backdrop
);
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);                                 // R2

    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);                               // R2

    AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_sel == 2'd3) |=> (rd_data == 32'd0));    // R10

    AST_BACKDROP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel != 2'd1) |=> $stable(backdrop));      // R11

    AST_BACKDROP_BYTE_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_sel == 2'd1 && req_size == 2'd0 &&
         req_addr[SMALL_AW-1:1] == '0)
        |=> (backdrop == {2{$past(req_wdata[7:0])}}));                          // R7

endmodule

bind vmem_front vmem_front_chk #(.SMALL_AW(SMALL_AW), .ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_sel  (req_sel),
    .req_size (req_size),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .backdrop (backdrop)
);

// File: tb/test_vmem_front.sv
`timescale 1ns/1ps
module test_vmem_front;
    localparam int BANK    = 512;
    localparam int VID_LEN = 3 * BANK;
    localparam int SML_LEN = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_sel = 2'd0;
    logic [1:0]  req_size = 2'd0;
    logic [31:0] req_addr = 32'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [2:0]  bg_mode = 3'd0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [15:0] backdrop;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] mv [VID_LEN];
    logic [7:0] mp [SML_LEN];
    logic [7:0] mo [SML_LEN];

    always #2.5 clk = ~clk;

    vmem_front #(.BANK_AW(9), .SMALL_AW(10), .ADDR_W(32)) i_vmem_front (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_sel(req_sel), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .bg_mode(bg_mode), .rd_valid(rd_valid),
        .rd_data(rd_data), .backdrop(backdrop)
    );

    function automatic int fold(input logic [1:0] sel, input logic [31:0] a);
        int m;
        if (sel == 2'd0) begin
            m = int'(a & 32'h7FF);
            if (m >= VID_LEN) m = 2 * BANK + (m % BANK);
            return m;
        end
        return int'(a & 32'h3FF);
    endfunction

    function automatic logic [7:0] rbyte(input logic [1:0] sel, input int o);
        case (sel)
            2'd0: return mv[o];
            2'd1: return mp[o];
            default: return mo[o];
        endcase
    endfunction

    task automatic wbyte(input logic [1:0] sel, input int o, input logic [7:0] v);
        case (sel)
            2'd0: mv[o] = v;
            2'd1: mp[o] = v;
            default: mo[o] = v;
        endcase
    endtask

    function automatic logic [31:0] mread(input logic [1:0] sel, input logic [1:0] sz,
                                          input logic [31:0] a);
        int o;
        if (sel == 2'd3) return 32'd0;
        o = fold(sel, a);
        if (sz == 2'd0) return {24'd0, rbyte(sel, o)};
        if (sz == 2'd1) begin
            o = o & ~1;
            return {16'd0, rbyte(sel, o + 1), rbyte(sel, o)};
        end
        o = o & ~3;
        return {rbyte(sel, o + 3), rbyte(sel, o + 2), rbyte(sel, o + 1), rbyte(sel, o)};
    endfunction

    task automatic mwrite(input logic [1:0] sel, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d);
        int o;
        if (sel == 2'd3) return;
        o = fold(sel, a);
        if (sz == 2'd0) begin
            if (sel == 2'd2) return;
            if (sel == 2'd0) begin
                if (bg_mode <= 3'd2 && o >= 2 * BANK) return;
                if (bg_mode > 3'd2 && o >= 2 * BANK + BANK / 2) return;
            end
            o = o & ~1;
            wbyte(sel, o, d[7:0]);
            wbyte(sel, o + 1, d[7:0]);
        end else if (sz == 2'd1) begin
            o = o & ~1;
            wbyte(sel, o, d[7:0]);
            wbyte(sel, o + 1, d[15:8]);
        end else begin
            o = o & ~3;
            for (int k = 0; k < 4; k++) wbyte(sel, o + k, d[8*k +: 8]);
        end
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic op(input string tag, input bit wr, input logic [1:0] sel,
                      input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
        logic [31:0] exp;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_sel   = sel;
        req_size  = sz;
        req_addr  = a;
        req_wdata = d;
        exp = mread(sel, sz, a);
        if (wr) mwrite(sel, sz, a, d);
        @(negedge clk);
        req_valid = 1'b0;
        chk(tag, "rd_valid", {31'd0, rd_valid}, {31'd0, !wr});
        if (!wr) chk(tag, "rd_data", rd_data, exp);
        chk("R11", "backdrop", {16'd0, backdrop}, {16'd0, mp[1], mp[0]});
    endtask

    initial begin
        for (int i = 0; i < VID_LEN; i++) mv[i] = 8'd0;
        for (int i = 0; i < SML_LEN; i++) begin
            mp[i] = 8'd0;
            mo[i] = 8'd0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rd_valid", {31'd0, rd_valid}, 32'd0);
        chk("R1", "backdrop", {16'd0, backdrop}, 32'd0);
        op("R1", 0, 2'd0, 2'd2, 32'h100, 0);
        op("R1", 0, 2'd1, 2'd2, 32'h3FC, 0);
        op("R1", 0, 2'd2, 2'd2, 32'h000, 0);

        // R6/R2 word write then reads of every width
        op("R6", 1, 2'd0, 2'd2, 32'h10, 32'hA1B2C3D4);
        op("R2", 0, 2'd0, 2'd2, 32'h10, 0);
        op("R2", 0, 2'd0, 2'd1, 32'h12, 0);
        op("R2", 0, 2'd0, 2'd0, 32'h11, 0);
        op("R2", 0, 2'd0, 2'd3, 32'h10, 0);
        // R3 misaligned forms
        op("R3", 0, 2'd0, 2'd2, 32'h13, 0);
        op("R3", 0, 2'd0, 2'd1, 32'h13, 0);
        op("R3", 1, 2'd0, 2'd1, 32'h21, 32'h00005566);
        op("R3", 0, 2'd0, 2'd2, 32'h20, 0);

        // R4 video fold
        op("R4", 1, 2'd0, 2'd2, 32'h620, 32'h11223344);
        op("R4", 0, 2'd0, 2'd2, 32'h420, 0);
        op("R4", 0, 2'd0, 2'd2, 32'h810, 0);
        op("R4", 0, 2'd0, 2'd2, 32'h7E0, 0);

        // R5 small-memory wrap, R7/R11 byte duplication into backdrop
        op("R5", 1, 2'd1, 2'd2, 32'h404, 32'hCAFEF00D);
        op("R5", 0, 2'd1, 2'd2, 32'h004, 0);
        op("R5", 1, 2'd2, 2'd1, 32'hC06, 32'h0000BEEF);
        op("R5", 0, 2'd2, 2'd2, 32'h004, 0);
        op("R7", 1, 2'd1, 2'd0, 32'h001, 32'h0000005A);
        op("R11", 1, 2'd1, 2'd1, 32'h400, 32'h00007C1F);
        op("R7", 1, 2'd0, 2'd0, 32'h033, 32'h000000E7);
        op("R7", 0, 2'd0, 2'd2, 32'h030, 0);

        // R8 object byte write has no effect
        op("R8", 1, 2'd2, 2'd2, 32'h8, 32'h01020304);
        op("R8", 1, 2'd2, 2'd0, 32'h9, 32'h000000FF);
        op("R8", 0, 2'd2, 2'd2, 32'h8, 0);

        // R9 object tile boundary by mode
        bg_mode = 3'd0;
        op("R9", 1, 2'd0, 2'd0, 32'h3FF, 32'h77);
        op("R9", 1, 2'd0, 2'd0, 32'h401, 32'h88);
        op("R9", 0, 2'd0, 2'd2, 32'h3FC, 0);
        op("R9", 0, 2'd0, 2'd2, 32'h400, 0);
        bg_mode = 3'd3;
        op("R9", 1, 2'd0, 2'd0, 32'h401, 32'h99);
        op("R9", 1, 2'd0, 2'd0, 32'h4FF, 32'h9A);
        op("R9", 1, 2'd0, 2'd0, 32'h501, 32'hAA);
        op("R9", 1, 2'd0, 2'd0, 32'h701, 32'hBB);
        op("R9", 0, 2'd0, 2'd2, 32'h400, 0);
        op("R9", 0, 2'd0, 2'd2, 32'h4FC, 0);
        op("R9", 0, 2'd0, 2'd2, 32'h500, 0);
        bg_mode = 3'd7;
        op("R9", 1, 2'd0, 2'd1, 32'h502, 32'h1357);
        op("R9", 0, 2'd0, 2'd2, 32'h500, 0);

        // R10 select 3
        op("R10", 1, 2'd3, 2'd2, 32'h10, 32'hFFFFFFFF);
        op("R10", 0, 2'd3, 2'd2, 32'h10, 0);
        op("R10", 0, 2'd0, 2'd2, 32'h10, 0);
        op("R10", 0, 2'd1, 2'd2, 32'h10, 0);
        op("R10", 0, 2'd2, 2'd2, 32'h10, 0);

        // Random sweep against the model
        for (int n = 0; n < 2000; n++) begin
            bg_mode = 3'($urandom % 8);
            op("R2", bit'($urandom % 2), 2'($urandom % 4), 2'($urandom % 4),
               $urandom % 4096, $urandom);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule